// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block decides when the chip may leave run mode and which of two low-power states it goes to. Entry starts only when the CPU has gone into a deep-sleep wait-for-interrupt, the radio is asleep and none of the masked wake lines is high. A single select input then chooses between a retentive stop and a full shutdown. In the retentive stop, the always-on logic moves onto the low-power regulator. The interruptible domain is powered off, and RAM bank 0 plus any software-enabled banks keep their contents.

Power-down runs as a fixed sequence: isolate, then gate clocks, then switch regulators. Power-up runs the same steps in reverse. Each step is held for a parameterised settle time. A wake line that rises during power-down cancels the entry and returns the controller to run mode without a reset. A wake from the stop state resets the interruptible domain on the way back up and stores the cause in a one-hot register, which software clears by writing ones. From shutdown, only a pulse on the external reset pin brings the chip back.

Top module: `lp_entry_ctrl`

## Requirements
- R1: Entry starts only in a cycle where sleepDeepReq=1, radioAsleep=1 and every wake line is 0. Otherwise the controller stays in run mode with isoEn=0 and clkEn=1.
- R2: The value of modeShutdown in the cycle entry starts selects the target state. With 0, the target is the retentive stop: mainRegEn=0, lpRegEn=1, aonLpSel=1. With 1, the target is shutdown: mainRegEn=0, lpRegEn=0, aonLpSel=0.
- R3: Power-down order. isoEn rises on the first clock edge that sees the entry condition. clkEn falls SETTLE_CYC cycles later. The regulator outputs switch SETTLE_CYC cycles after that.
- R4: A wake line seen in the stop state sets mainRegEn=1 and aonLpSel=0 on the next edge. clkEn returns SETTLE_CYC cycles later. isoEn falls, and intRstN is released, SETTLE_CYC cycles after that.
- R5: intRstN is 0 whenever rstPinN is 0. It is also 0 in the stop state, in shutdown and throughout power-up. It is 1 in run mode and throughout the power-down sequence.
- R6: A wake line seen while the power-down sequence is running returns the controller to run mode on the next edge (isoEn=0, clkEn=1). intRstN stays 1 and wakeReason is left unchanged.
- R7: While in the stop state, bankRetain[0]=1 and bankRetain[k] (k≥1) equals retainEn[k] as sampled in the cycle entry started. Later changes to retainEn have no effect, and retainEn[0] is ignored. Outside the stop state, bankRetain is all zeros.
- R8: Leaving the stop state loads wakeReason with exactly one bit. The bits are: 0 radio timer, 1 host timer, 2 RTC, 3 any GPIO line, 4 watchdog. When several sources are high together, the priority is watchdog, radio, host, RTC, GPIO.
- R9: With reasonClrWe=1, each wakeReason bit whose reasonClrMask bit is 1 clears on the next edge. Other bits are kept. A wake load in the same cycle takes precedence over the clear.
- R10: In shutdown, all wake lines are ignored and the outputs stay fixed. Only rstPinN low then high returns the controller to run mode, with wakeReason=0.
- R11: While rstPinN is low and after it is released, the outputs are isoEn=0, clkEn=1, mainRegEn=1, lpRegEn=1, aonLpSel=0, bankRetain=0 and wakeReason=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstPinN | input | 1 | External reset pin, active low, asynchronous |
| sleepDeepReq | input | 1 | CPU is in deep-sleep wait-for-interrupt |
| radioAsleep | input | 1 | Radio reports no activity |
| modeShutdown | input | 1 | 0 selects retentive stop, 1 selects shutdown |
| retainEn | input | NUM_BANKS | Software retention enables per RAM bank (bit 0 ignored) |
| wakeRadio | input | 1 | Radio wake-up timer event (masked) |
| wakeHost | input | 1 | CPU host wake-up timer event (masked) |
| wakeRtc | input | 1 | RTC wake event (masked) |
| wakeGpio | input | NUM_GPIO | GPIO wake lines (masked) |
| wakeWdog | input | 1 | Watchdog reset event |
| reasonClrWe | input | 1 | Write strobe for clearing wake reason bits |
| reasonClrMask | input | 5 | Ones select the wake reason bits to clear |
| isoEn | output | 1 | Isolation of the interruptible domain |
| clkEn | output | 1 | System and bus clock enable |
| mainRegEn | output | 1 | Main regulator enable |
| lpRegEn | output | 1 | Low-power regulator enable |
| aonLpSel | output | 1 | Always-on domain fed from the low-power regulator |
| intRstN | output | 1 | Interruptible domain reset, active low |
| bankRetain | output | NUM_BANKS | Retention control per RAM bank |
| wakeReason | output | 5 | Latched one-hot wake cause |

## Verification
The bench builds the block with SETTLE_CYC=3, NUM_GPIO=5 and NUM_BANKS=4. A three-cycle settle makes each sequence step long enough to land a wake pulse in the middle of it, so the bench can cancel entry from both the isolation step and the clock-gate step. It stays short enough to run many full entry and wake round trips. With five GPIO lines, the bench can combine a GPIO wake with other sources in the same cycle to test the wake priority. With four banks, it can test a retention pattern that mixes enabled and disabled banks, and show that the pattern is frozen once entry has started.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  localparam int REASON_W  = 5;
  localparam int RSN_RADIO = 0;
  localparam int RSN_HOST  = 1;
  localparam int RSN_RTC   = 2;
  localparam int RSN_GPIO  = 3;
  localparam int RSN_WDOG  = 4;

  typedef enum logic [2:0] {
    ST_RUN, ST_DN_ISO, ST_DN_CLK, ST_STOP, ST_SHUT, ST_UP_REG, ST_UP_CLK
  } pwrState_t;

  typedef struct packed {
    logic captureRetain;
    logic latchWake;
    logic holdRetain;
  } dpStrobe_t;
endpackage

// File: rtl/lpc_ctrl.sv
module lpc_ctrl
  import lpc_pkg::*;
#(
  parameter int SETTLE_CYC = 4
) (
  input  logic      clk,
  input  logic      rstPinN,
  input  logic      sleepDeepReq,
  input  logic      radioAsleep,
  input  logic      anyWake,
  input  logic      modeShutdown,
  output dpStrobe_t strb,
  output logic      isoEn,
  output logic      clkEn,
  output logic      mainRegEn,
  output logic      lpRegEn,
  output logic      aonLpSel,
  output logic      intRstN
);
  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

  pwrState_t state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic modeLat;
  logic entryOk, stepDone;

  assign entryOk  = sleepDeepReq & radioAsleep & ~anyWake;
  assign stepDone = (cnt == CNT_LAST);

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    case (state)
      ST_RUN: if (entryOk) begin stateNext = ST_DN_ISO; cntNext = '0; end
      ST_DN_ISO: begin
        if (anyWake) stateNext = ST_RUN;
        else if (stepDone) begin stateNext = ST_DN_CLK; cntNext = '0; end
        else cntNext = cnt + CNT_W'(1);
      end
      ST_DN_CLK: begin
        if (anyWake) stateNext = ST_RUN;
        else if (stepDone) begin
          stateNext = modeLat ? ST_SHUT : ST_STOP;
          cntNext   = '0;
        end else cntNext = cnt + CNT_W'(1);
      end
      ST_STOP: if (anyWake) begin stateNext = ST_UP_REG; cntNext = '0; end
      ST_SHUT: stateNext = ST_SHUT;
      ST_UP_REG: begin
        if (stepDone) begin stateNext = ST_UP_CLK; cntNext = '0; end
        else cntNext = cnt + CNT_W'(1);
      end
      ST_UP_CLK: begin
        if (stepDone) begin stateNext = ST_RUN; cntNext = '0; end
        else cntNext = cnt + CNT_W'(1);
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstPinN) begin
    if (!rstPinN) begin
      state   <= ST_RUN;
      cnt     <= '0;
      modeLat <= 1'b0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
      if (state == ST_RUN && entryOk) modeLat <= modeShutdown;
    end
  end

  assign strb.captureRetain = (state == ST_RUN) && entryOk;
  assign strb.latchWake     = (state == ST_STOP) && anyWake;
  assign strb.holdRetain    = (state == ST_STOP);

  assign isoEn     = (state != ST_RUN);
  assign clkEn     = (state inside {ST_RUN, ST_DN_ISO, ST_UP_CLK});
  assign mainRegEn = !(state inside {ST_STOP, ST_SHUT});
  assign lpRegEn   = (state != ST_SHUT);
  assign aonLpSel  = (state == ST_STOP);
  assign intRstN   = rstPinN && !(state inside {ST_STOP, ST_SHUT, ST_UP_REG, ST_UP_CLK});

  p_entry_cond_r1: assert property (@(posedge clk) disable iff (!rstPinN)
    $rose(isoEn) |-> $past(sleepDeepReq && radioAsleep && !anyWake));
  p_iso_before_clk_r3: assert property (@(posedge clk) disable iff (!rstPinN)
    $fell(clkEn) |-> $past(isoEn));
  p_clk_before_reg_r3: assert property (@(posedge clk) disable iff (!rstPinN)
    $fell(mainRegEn) |-> $past(!clkEn));
  p_iso_release_last_r4: assert property (@(posedge clk) disable iff (!rstPinN)
    $fell(isoEn) |-> (clkEn && mainRegEn));
  p_shut_sticky_r10: assert property (@(posedge clk) disable iff (!rstPinN)
    (state == ST_SHUT) |=> (state == ST_SHUT));
endmodule

// File: rtl/lpc_datapath.sv
module lpc_datapath
  import lpc_pkg::*;
#(
  parameter int NUM_GPIO  = 28,
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rstPinN,
  input  dpStrobe_t            strb,
  input  logic                 wakeRadio,
  input  logic                 wakeHost,
  input  logic                 wakeRtc,
  input  logic [NUM_GPIO-1:0]  wakeGpio,
  input  logic                 wakeWdog,
  input  logic [NUM_BANKS-1:0] retainEn,
  input  logic                 reasonClrWe,
  input  logic [REASON_W-1:0]  reasonClrMask,
  output logic                 anyWake,
  output logic [NUM_BANKS-1:0] bankRetain,
  output logic [REASON_W-1:0]  wakeReason
);
  logic [REASON_W-1:0]  pick;
  logic [NUM_BANKS-1:0] snap;

  assign anyWake = wakeRadio | wakeHost | wakeRtc | (|wakeGpio) | wakeWdog;

  always_comb begin
    pick = '0;
    if (wakeWdog)       pick[RSN_WDOG]  = 1'b1;
    else if (wakeRadio) pick[RSN_RADIO] = 1'b1;
    else if (wakeHost)  pick[RSN_HOST]  = 1'b1;
    else if (wakeRtc)   pick[RSN_RTC]   = 1'b1;
    else if (|wakeGpio) pick[RSN_GPIO]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rstPinN) begin
    if (!rstPinN) wakeReason <= '0;
    else if (strb.latchWake) wakeReason <= pick;
    else if (reasonClrWe) wakeReason <= wakeReason & ~reasonClrMask;
  end

  always_ff @(posedge clk or negedge rstPinN) begin
    if (!rstPinN) snap <= '0;
    else if (strb.captureRetain) snap <= retainEn | NUM_BANKS'(1);
  end

  assign bankRetain = {NUM_BANKS{strb.holdRetain}} & snap;

  p_reason_onehot_r8: assert property (@(posedge clk) disable iff (!rstPinN)
    $onehot0(wakeReason));
  p_retain_frozen_r7: assert property (@(posedge clk) disable iff (!rstPinN)
    (strb.holdRetain && $past(strb.holdRetain)) |-> $stable(bankRetain));
  p_clear_applied_r9: assert property (@(posedge clk) disable iff (!rstPinN)
    (reasonClrWe && !strb.latchWake) |=> ((wakeReason & $past(reasonClrMask)) == '0));
endmodule

// File: rtl/lp_entry_ctrl.sv
module lp_entry_ctrl
  import lpc_pkg::*;
#(
  parameter int NUM_GPIO   = 28,
  parameter int NUM_BANKS  = 4,
  parameter int SETTLE_CYC = 4
) (
  input  logic                 clk,
  input  logic                 rstPinN,
  input  logic                 sleepDeepReq,
  input  logic                 radioAsleep,
  input  logic                 modeShutdown,
  input  logic [NUM_BANKS-1:0] retainEn,
  input  logic                 wakeRadio,
  input  logic                 wakeHost,
  input  logic                 wakeRtc,
  input  logic [NUM_GPIO-1:0]  wakeGpio,
  input  logic                 wakeWdog,
  input  logic                 reasonClrWe,
  input  logic [4:0]           reasonClrMask,
  output logic                 isoEn,
  output logic                 clkEn,
  output logic                 mainRegEn,
  output logic                 lpRegEn,
  output logic                 aonLpSel,
  output logic                 intRstN,
  output logic [NUM_BANKS-1:0] bankRetain,
  output logic [4:0]           wakeReason
);
  dpStrobe_t strb;
  logic anyWake;

  lpc_ctrl #(.SETTLE_CYC(SETTLE_CYC)) uCtrl (
    .clk(clk), .rstPinN(rstPinN), .sleepDeepReq(sleepDeepReq),
    .radioAsleep(radioAsleep), .anyWake(anyWake), .modeShutdown(modeShutdown),
    .strb(strb), .isoEn(isoEn), .clkEn(clkEn), .mainRegEn(mainRegEn),
    .lpRegEn(lpRegEn), .aonLpSel(aonLpSel), .intRstN(intRstN)
  );

  lpc_datapath #(.NUM_GPIO(NUM_GPIO), .NUM_BANKS(NUM_BANKS)) uDp (
    .clk(clk), .rstPinN(rstPinN), .strb(strb),
    .wakeRadio(wakeRadio), .wakeHost(wakeHost), .wakeRtc(wakeRtc),
    .wakeGpio(wakeGpio), .wakeWdog(wakeWdog), .retainEn(retainEn),
    .reasonClrWe(reasonClrWe), .reasonClrMask(reasonClrMask),
    .anyWake(anyWake), .bankRetain(bankRetain), .wakeReason(wakeReason)
  );
endmodule

// File: tb/lp_entry_ctrl_test.sv
module lp_entry_ctrl_test;
  localparam int GP = 5;
  localparam int NB = 4;
  localparam int SC = 3;

  logic clk = 1'b0;
  logic rstPinN = 1'b0;
  logic sleepDeepReq = 0, radioAsleep = 0, modeShutdown = 0;
  logic [NB-1:0] retainEn = '0;
  logic wakeRadio = 0, wakeHost = 0, wakeRtc = 0, wakeWdog = 0;
  logic [GP-1:0] wakeGpio = '0;
  logic reasonClrWe = 0;
  logic [4:0] reasonClrMask = '0;
  logic isoEn, clkEn, mainRegEn, lpRegEn, aonLpSel, intRstN;
  logic [NB-1:0] bankRetain;
  logic [4:0] wakeReason;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lp_entry_ctrl #(.NUM_GPIO(GP), .NUM_BANKS(NB), .SETTLE_CYC(SC)) uut (
    .clk(clk), .rstPinN(rstPinN), .sleepDeepReq(sleepDeepReq),
    .radioAsleep(radioAsleep), .modeShutdown(modeShutdown), .retainEn(retainEn),
    .wakeRadio(wakeRadio), .wakeHost(wakeHost), .wakeRtc(wakeRtc),
    .wakeGpio(wakeGpio), .wakeWdog(wakeWdog), .reasonClrWe(reasonClrWe),
    .reasonClrMask(reasonClrMask), .isoEn(isoEn), .clkEn(clkEn),
    .mainRegEn(mainRegEn), .lpRegEn(lpRegEn), .aonLpSel(aonLpSel),
    .intRstN(intRstN), .bankRetain(bankRetain), .wakeReason(wakeReason)
  );

  // Behavioural reference: phase 0 run, 1 isolating, 2 clocks gated,
  // 3 stop, 4 shutdown, 5 regulators back, 6 clocks back.
  int mPhase = 0;
  int mTick = 0;
  bit mShut = 0;
  bit [NB-1:0] mKeep = '0;
  bit [4:0] mCause = '0;

  always @(posedge clk or negedge rstPinN) begin
    if (!rstPinN) begin
      mPhase = 0; mTick = 0; mShut = 0; mKeep = '0; mCause = '0;
    end else begin
      bit w;
      bit [4:0] c;
      w = wakeRadio || wakeHost || wakeRtc || (wakeGpio != 0) || wakeWdog;
      c = 0;
      if (wakeWdog) c = 5'b10000;
      else if (wakeRadio) c = 5'b00001;
      else if (wakeHost) c = 5'b00010;
      else if (wakeRtc) c = 5'b00100;
      else if (wakeGpio != 0) c = 5'b01000;
      if (mPhase == 3 && w) mCause = c;
      else if (reasonClrWe) mCause = mCause & ~reasonClrMask;
      if (mPhase == 0) begin
        if (sleepDeepReq && radioAsleep && !w) begin
          mPhase = 1; mTick = 1; mShut = modeShutdown;
          mKeep = retainEn; mKeep[0] = 1'b1;
        end
      end else if (mPhase == 1 || mPhase == 2) begin
        if (w) mPhase = 0;
        else if (mTick == SC) begin
          mPhase = (mPhase == 1) ? 2 : (mShut ? 4 : 3); mTick = 1;
        end else mTick++;
      end else if (mPhase == 3) begin
        if (w) begin mPhase = 5; mTick = 1; end
      end else if (mPhase == 5 || mPhase == 6) begin
        if (mTick == SC) begin mPhase = (mPhase == 5) ? 6 : 0; mTick = 1; end
        else mTick++;
      end
    end
  end

  task automatic chk(string what, string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (!finished) begin
      chk("isoEn", "R3", 8'(isoEn), 8'(mPhase != 0));
      chk("clkEn", "R3", 8'(clkEn), 8'(mPhase == 0 || mPhase == 1 || mPhase == 6));
      chk("mainRegEn", "R2", 8'(mainRegEn), 8'(!(mPhase == 3 || mPhase == 4)));
      chk("lpRegEn", "R2", 8'(lpRegEn), 8'(mPhase != 4));
      chk("aonLpSel", "R2", 8'(aonLpSel), 8'(mPhase == 3));
      chk("intRstN", "R5", 8'(intRstN), 8'(rstPinN && (mPhase <= 2)));
      chk("bankRetain", "R7", 8'(bankRetain), 8'((mPhase == 3) ? mKeep : '0));
      chk("wakeReason", "R8", 8'(wakeReason), 8'(mCause));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter(bit shut);
    modeShutdown = shut; sleepDeepReq = 1; radioAsleep = 1;
    cyc(1);
    sleepDeepReq = 0;
    cyc(2 * SC + 2);
  endtask

  task automatic pulseWake(bit r, bit h, bit t, bit [GP-1:0] g, bit d);
    wakeRadio = r; wakeHost = h; wakeRtc = t; wakeGpio = g; wakeWdog = d;
    cyc(1);
    wakeRadio = 0; wakeHost = 0; wakeRtc = 0; wakeGpio = '0; wakeWdog = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(2);
    // R11 reset values while the pin is low
    chk("reset intRstN", "R11", 8'(intRstN), 8'd0);
    chk("reset clkEn", "R11", 8'(clkEn), 8'd1);
    rstPinN = 1;
    cyc(1);
    chk("reset isoEn", "R11", 8'(isoEn), 8'd0);
    chk("reset wakeReason", "R11", 8'(wakeReason), 8'd0);
    chk("reset bankRetain", "R11", 8'(bankRetain), 8'd0);

    // R1 entry blocked by an awake radio, then by an active wake line
    sleepDeepReq = 1; radioAsleep = 0;
    cyc(4);
    chk("no entry radio awake", "R1", 8'(isoEn), 8'd0);
    radioAsleep = 1; wakeRtc = 1;
    cyc(4);
    chk("no entry wake active", "R1", 8'(isoEn), 8'd0);
    sleepDeepReq = 0; wakeRtc = 0; radioAsleep = 0;
    cyc(1);

    // R2/R7 stop entry with a mixed retention pattern, bit 0 clear
    retainEn = 4'b1010;
    enter(0);
    chk("stop aonLpSel", "R2", 8'(aonLpSel), 8'd1);
    chk("stop bankRetain", "R7", 8'(bankRetain), 8'b1011);
    retainEn = 4'b0000;
    cyc(3);
    chk("retain frozen", "R7", 8'(bankRetain), 8'b1011);
    chk("stop intRstN", "R5", 8'(intRstN), 8'd0);
    // R8 RTC outranks GPIO
    pulseWake(0, 0, 1, 5'b00100, 0);
    chk("wake regulator first", "R4", 8'(mainRegEn), 8'd1);
    cyc(2 * SC + 2);
    chk("back in run iso", "R4", 8'(isoEn), 8'd0);
    chk("back in run reset", "R4", 8'(intRstN), 8'd1);
    chk("reason rtc", "R8", 8'(wakeReason), 8'b00100);

    // R9 write-one-to-clear
    reasonClrWe = 1; reasonClrMask = 5'b00100;
    cyc(1);
    reasonClrWe = 0;
    chk("clear rtc", "R9", 8'(wakeReason), 8'd0);

    // R8 watchdog outranks radio
    enter(0);
    pulseWake(1, 0, 0, '0, 1);
    cyc(2 * SC + 2);
    chk("reason wdog", "R8", 8'(wakeReason), 8'b10000);
    reasonClrWe = 1; reasonClrMask = 5'b00001;
    cyc(1);
    reasonClrWe = 0;
    chk("clear other bit keeps", "R9", 8'(wakeReason), 8'b10000);

    // R6 abort during isolation step
    sleepDeepReq = 1; radioAsleep = 1;
    cyc(1);
    chk("isolating", "R3", 8'(isoEn), 8'd1);
    sleepDeepReq = 0;
    pulseWake(0, 1, 0, '0, 0);
    chk("abort iso clk", "R6", 8'(clkEn), 8'd1);
    chk("abort iso isoEn", "R6", 8'(isoEn), 8'd0);
    chk("abort iso reason", "R6", 8'(wakeReason), 8'b10000);

    // R6 abort during clock-gate step
    sleepDeepReq = 1;
    cyc(1);
    sleepDeepReq = 0;
    cyc(SC + 1);
    chk("clocks gated", "R3", 8'(clkEn), 8'd0);
    pulseWake(0, 0, 0, 5'b00001, 0);
    chk("abort clk clkEn", "R6", 8'(clkEn), 8'd1);
    chk("abort clk intRstN", "R6", 8'(intRstN), 8'd1);
    chk("abort clk reason", "R6", 8'(wakeReason), 8'b10000);
    cyc(2);

    // R10 shutdown ignores every wake line
    retainEn = 4'b1110;
    enter(1);
    chk("shut mainRegEn", "R10", 8'(mainRegEn), 8'd0);
    chk("shut lpRegEn", "R10", 8'(lpRegEn), 8'd0);
    chk("shut bankRetain", "R7", 8'(bankRetain), 8'd0);
    wakeRadio = 1; wakeHost = 1; wakeRtc = 1; wakeGpio = '1; wakeWdog = 1;
    cyc(3);
    wakeRadio = 0; wakeHost = 0; wakeRtc = 0; wakeGpio = '0; wakeWdog = 0;
    cyc(4);
    chk("shut ignores wake", "R10", 8'(mainRegEn), 8'd0);
    chk("shut reason kept", "R10", 8'(wakeReason), 8'b10000);
    rstPinN = 0;
    cyc(1);
    chk("pin low intRstN", "R5", 8'(intRstN), 8'd0);
    rstPinN = 1; modeShutdown = 0; radioAsleep = 0;
    cyc(1);
    chk("pin exit clkEn", "R10", 8'(clkEn), 8'd1);
    chk("pin exit reason", "R10", 8'(wakeReason), 8'd0);
    chk("pin exit regs", "R11", 8'(mainRegEn), 8'd1);
    cyc(3);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule